// File: doc/BRIEF.md
# Dual-Clock Frequency Comparator

This block decides whether a clock under test runs at the expected rate relative to a trusted reference clock. Two down-counters run, one on each clock. The reference-side counter first counts a start seed down to zero and then counts a second, shorter seed that forms an acceptance window. The test-side counter counts its own seed down to zero. The measurement passes only when the test-side counter reaches zero while the window is open. If it reaches zero too soon, or has still not reached zero when the window closes, the measurement fails.

Software works the block through a small register file clocked by the bus clock. It loads the three seeds and picks which of several test clocks drives the test-side counter. It then arms the block through a control word made of 4-bit keyed fields. Completion shows up as a done or error flag in a status word, and each flag can raise an interrupt. In one-shot mode a single measurement runs. In repeating mode every pass reloads both counters and measures again, until a failure halts the block. Start, stop and result events cross between the bus, reference and test clock domains through two-flop synchronizers.

Top module: `fcmp_top`

Register word addresses: 0 control, 1 status, 2 reference start seed, 3 window seed, 4 test seed, 5 test source select, 6 reference counter readback, 7 test counter readback.

## Requirements
- R1: After reset the status word (address 1) reads 0, the control word (address 0) reads 0x5555, and both interrupt outputs are low.
- R2: The control word holds four 4-bit keyed fields: run enable in bits 3:0, error-interrupt enable in bits 7:4, one-shot select in bits 11:8, and done-interrupt enable in bits 15:12. In each field 0xA means on and 0x5 means off. Writing any other value to a field stores 0x5 in that field and sets the error flag.
- R3: Status bit 0 is the error flag and status bit 1 is the done flag. Writing 1 to a status bit clears only that bit. A result that arrives in the same cycle as the clearing write takes priority.
- R4: A write to the source select (address 5) takes effect only when bits 15:12 hold 0xA. With any other key the previously selected source stays in place. The stored source number reads back in the low bits.
- R5: When the test counter reaches zero while the reference counter is counting down its window seed, the measurement ends with status equal to 2 (done set, error clear).
- R6: When the test counter reaches zero before the reference counter has finished its start seed, the measurement ends with status equal to 1 (error set, done clear).
- R7: When the window countdown ends before the test counter reaches zero, the measurement ends with status equal to 1, and the reference counter readback (address 6) is 0.
- R8: In one-shot mode (one-shot field 0xA), counting stops after a result. Status and both counter readbacks stay unchanged afterwards, and the test counter readback (address 7) is 0 after a pass.
- R9: In repeating mode (one-shot field 0x5), a pass sets done and starts a fresh measurement. A failure sets error and halts counting: after the status is cleared, no further flag appears until the control word is written again.
- R10: The error interrupt output is high exactly while the error flag is set and the error-interrupt field holds 0xA. The done interrupt output behaves the same way with the done flag and the done-interrupt field.
- R11: A measurement starts only when the run enable field is 0xA and both status flags are clear. Writing 0x5 to the run enable field during a measurement abandons it without setting any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| rst | input | 1 | Synchronous active-high reset, synchronized into every domain |
| ref_clk | input | 1 | Reference clock for the reference-side counter |
| tst_clks | input | NSRC | Candidate clocks under test |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for the addressed register (combinational) |
| irq_err | output | 1 | Error interrupt |
| irq_done | output | 1 | Done interrupt |

## Verification
The assertions watch the bus-clock side on every cycle. They check that every stored keyed field is a legal code and that the run request falls one cycle after the enable is withdrawn. They also check that status flags rise only after a measurement result, that write-one-to-clear works, that a source write with a wrong key leaves the selection unchanged, and that an interrupt is never raised without its flag. Whether a given ratio between the clocks passes or fails depends on real multi-clock timing and on the early, in-window and late arrival cases. The same applies to the automatic restart in repeating mode, the halt after a failure, and the frozen counter readbacks. Only the bench scenarios can show these behaviours, using several test clock sources.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam logic [3:0] KEY_ON  = 4'hA;
    localparam logic [3:0] KEY_OFF = 4'h5;

    typedef enum logic [2:0] {
        A_CTRL   = 3'd0,
        A_STAT   = 3'd1,
        A_SEED0  = 3'd2,
        A_WIN0   = 3'd3,
        A_SEED1  = 3'd4,
        A_SRC    = 3'd5,
        A_CNT0   = 3'd6,
        A_CNT1   = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [3:0] done_ie;
        logic [3:0] oneshot;
        logic [3:0] err_ie;
        logic [3:0] enable;
    } ctrl_t;

    typedef enum logic [1:0] {
        B_IDLE,
        B_RUN,
        B_WAIT,
        B_STOP
    } bus_st_e;

    typedef enum logic [1:0] {
        P_IDLE,
        P_COUNT,
        P_WINDOW,
        P_END
    } ref_ph_e;

    function automatic logic key_bad(input logic [3:0] k);
        return (k != KEY_ON) && (k != KEY_OFF);
    endfunction

    function automatic logic [3:0] key_fix(input logic [3:0] k);
        return key_bad(k) ? KEY_OFF : k;
    endfunction

    function automatic logic key_on(input logic [3:0] k);
        return k == KEY_ON;
    endfunction

endpackage

// File: rtl/fcmp_sync.sv
module fcmp_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/fcmp_ref.sv
module fcmp_ref
    import fcmp_pkg::*;
#(
    parameter int CW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          z1,
    input  logic [CW-1:0] seed0,
    input  logic [CW-1:0] win0,
    output logic          done,
    output logic          fail,
    output logic [CW-1:0] cnt
);

    ref_ph_e ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= P_IDLE;
            cnt  <= '0;
            fail <= 1'b0;
        end else begin
            case (ph)
                P_IDLE: begin
                    if (go && !z1) begin
                        cnt  <= seed0;
                        fail <= 1'b0;
                        ph   <= P_COUNT;
                    end
                end
                P_COUNT: begin
                    if (!go) begin
                        ph <= P_IDLE;
                    end else if (z1) begin
                        fail <= 1'b1;
                        ph   <= P_END;
                    end else if (cnt == '0) begin
                        cnt <= win0;
                        ph  <= P_WINDOW;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                P_WINDOW: begin
                    if (!go) begin
                        ph <= P_IDLE;
                    end else if (z1) begin
                        fail <= 1'b0;
                        ph   <= P_END;
                    end else if (cnt == '0) begin
                        fail <= 1'b1;
                        ph   <= P_END;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                P_END: begin
                    if (!go && !z1) ph <= P_IDLE;
                end
                default: ph <= P_IDLE;
            endcase
        end
    end

    assign done = (ph == P_END);

endmodule

// File: rtl/fcmp_tst.sv
module fcmp_tst #(
    parameter int CW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [CW-1:0] seed1,
    output logic          zero,
    output logic          act,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            zero <= 1'b0;
            act  <= 1'b0;
        end else begin
            act <= go;
            if (go && !act) begin
                cnt  <= seed1;
                zero <= 1'b0;
            end else if (!go) begin
                zero <= 1'b0;
            end else if (cnt == '0) begin
                zero <= 1'b1;
            end else begin
                cnt <= cnt - CW'(1);
            end
        end
    end

endmodule

// File: rtl/fcmp_bus.sv
module fcmp_bus
    import fcmp_pkg::*;
#(
    parameter int CW = 20,
    parameter int SW = 2,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [2:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          done_s,
    input  logic          fail_s,
    input  logic          tact_s,
    input  logic [CW-1:0] cnt0,
    input  logic [CW-1:0] cnt1,
    output ctrl_t         ctrl,
    output logic          st_err,
    output logic          st_done,
    output logic          go,
    output logic          res_evt,
    output logic [CW-1:0] seed0,
    output logic [CW-1:0] win0,
    output logic [CW-1:0] seed1,
    output logic [SW-1:0] src
);

    bus_st_e   st;
    logic      rerun;
    ctrl_t     wc;
    logic      wr_ctrl;
    logic      wr_stat;
    logic      key_err;
    logic      meas_idle;
    logic      unused_bits;
    reg_addr_e ra;

    assign ra          = reg_addr_e'(addr);
    assign wc          = ctrl_t'(wdata[15:0]);
    assign wr_ctrl     = we && (ra == A_CTRL);
    assign wr_stat     = we && (ra == A_STAT);
    assign key_err     = wr_ctrl && (key_bad(wc.enable) || key_bad(wc.err_ie) ||
                                     key_bad(wc.oneshot) || key_bad(wc.done_ie));
    assign go          = (st == B_RUN);
    assign res_evt     = (st == B_RUN) && done_s && key_on(ctrl.enable);
    assign meas_idle   = (st == B_IDLE) || (st == B_STOP);
    assign unused_bits = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '{KEY_OFF, KEY_OFF, KEY_OFF, KEY_OFF};
            st_err  <= 1'b0;
            st_done <= 1'b0;
            seed0   <= '0;
            win0    <= '0;
            seed1   <= '0;
            src     <= '0;
            st      <= B_IDLE;
            rerun   <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl <= '{key_fix(wc.done_ie), key_fix(wc.oneshot),
                          key_fix(wc.err_ie), key_fix(wc.enable)};
            end
            if (we && ra == A_SEED0) seed0 <= wdata[CW-1:0];
            if (we && ra == A_WIN0)  win0  <= wdata[CW-1:0];
            if (we && ra == A_SEED1) seed1 <= wdata[CW-1:0];
            if (we && ra == A_SRC && wdata[15:12] == KEY_ON) src <= wdata[SW-1:0];

            st_err  <= (st_err  && !(wr_stat && wdata[0])) || key_err || (res_evt && fail_s);
            st_done <= (st_done && !(wr_stat && wdata[1])) || (res_evt && !fail_s);

            case (st)
                B_IDLE: begin
                    if (key_on(ctrl.enable) && !st_err && !st_done) st <= B_RUN;
                end
                B_RUN: begin
                    if (!key_on(ctrl.enable)) begin
                        rerun <= 1'b0;
                        st    <= B_WAIT;
                    end else if (done_s) begin
                        rerun <= !key_on(ctrl.oneshot) && !fail_s;
                        st    <= B_WAIT;
                    end
                end
                B_WAIT: begin
                    if (!done_s && !tact_s) begin
                        st <= (rerun && key_on(ctrl.enable) && !st_err) ? B_RUN : B_STOP;
                    end
                end
                B_STOP: begin
                    if (wr_ctrl) st <= B_IDLE;
                end
                default: st <= B_IDLE;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (ra)
            A_CTRL:  rdata = DW'(ctrl);
            A_STAT:  rdata = DW'({st_done, st_err});
            A_SEED0: rdata = DW'(seed0);
            A_WIN0:  rdata = DW'(win0);
            A_SEED1: rdata = DW'(seed1);
            A_SRC:   rdata = DW'(src);
            A_CNT0:  rdata = meas_idle ? DW'(cnt0) : '0;
            A_CNT1:  rdata = meas_idle ? DW'(cnt1) : '0;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/fcmp_top.sv
module fcmp_top
    import fcmp_pkg::*;
#(
    parameter int CW   = 20,
    parameter int NSRC = 4,
    parameter int DW   = 32
) (
    input  logic            bus_clk,
    input  logic            rst,
    input  logic            ref_clk,
    input  logic [NSRC-1:0] tst_clks,
    input  logic            bus_we,
    input  logic [2:0]      bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            irq_err,
    output logic            irq_done
);

    localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;

    ctrl_t         ctrl;
    logic          st_err, st_done, go, res_evt;
    logic [CW-1:0] seed0, win0, seed1, cnt0, cnt1;
    logic [SW-1:0] src;
    logic          tst_clk;
    logic          rst_r, rst_t;
    logic          go_r, go_t, z1_r;
    logic          zero_t, act_t, act_b;
    logic          done_r, fail_r, done_b, fail_b;

    assign tst_clk = tst_clks[src];

    fcmp_sync #(.W(1)) u_rst_r (.clk(ref_clk), .rst(1'b0), .d(rst), .q(rst_r));
    fcmp_sync #(.W(1)) u_rst_t (.clk(tst_clk), .rst(1'b0), .d(rst), .q(rst_t));
    fcmp_sync #(.W(1)) u_go_r  (.clk(ref_clk), .rst(rst_r), .d(go), .q(go_r));
    fcmp_sync #(.W(1)) u_go_t  (.clk(tst_clk), .rst(rst_t), .d(go), .q(go_t));
    fcmp_sync #(.W(1)) u_z1_r  (.clk(ref_clk), .rst(rst_r), .d(zero_t), .q(z1_r));
    fcmp_sync #(.W(2)) u_res_b (.clk(bus_clk), .rst(rst), .d({done_r, fail_r}),
                                .q({done_b, fail_b}));
    fcmp_sync #(.W(1)) u_act_b (.clk(bus_clk), .rst(rst), .d(act_t), .q(act_b));

    fcmp_bus #(.CW(CW), .SW(SW), .DW(DW)) u_bus (
        .clk(bus_clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .rdata(bus_rdata), .done_s(done_b), .fail_s(fail_b), .tact_s(act_b),
        .cnt0(cnt0), .cnt1(cnt1), .ctrl(ctrl), .st_err(st_err), .st_done(st_done),
        .go(go), .res_evt(res_evt), .seed0(seed0), .win0(win0), .seed1(seed1), .src(src)
    );

    fcmp_ref #(.CW(CW)) u_ref (
        .clk(ref_clk), .rst(rst_r), .go(go_r), .z1(z1_r), .seed0(seed0), .win0(win0),
        .done(done_r), .fail(fail_r), .cnt(cnt0)
    );

    fcmp_tst #(.CW(CW)) u_tst (
        .clk(tst_clk), .rst(rst_t), .go(go_t), .seed1(seed1),
        .zero(zero_t), .act(act_t), .cnt(cnt1)
    );

    assign irq_err  = st_err  && key_on(ctrl.err_ie);
    assign irq_done = st_done && key_on(ctrl.done_ie);

endmodule

// File: rtl/fcmp_chk.sv
module fcmp_chk
    import fcmp_pkg::*;
#(
    parameter int SW = 2,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_we,
    input logic [2:0]    bus_addr,
    input logic [DW-1:0] bus_wdata,
    input ctrl_t         ctrl,
    input logic          st_err,
    input logic          st_done,
    input logic          res_evt,
    input logic          go,
    input logic [SW-1:0] src,
    input logic          irq_err,
    input logic          irq_done
);

    logic unused_chk;
    assign unused_chk = ^bus_wdata;

    AST_KEYS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        !key_bad(ctrl.enable) && !key_bad(ctrl.err_ie) &&
        !key_bad(ctrl.oneshot) && !key_bad(ctrl.done_ie));  // R2

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 3'd1 && bus_wdata[1] && !res_evt) |=> !st_done);  // R3

    AST_SRC_KEYED: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 3'd5 && bus_wdata[15:12] != KEY_ON) |=> $stable(src));  // R4

    AST_DONE_FROM_RESULT: assert property (@(posedge clk) disable iff (rst)
        $rose(st_done) |-> $past(res_evt));  // R5

    AST_GO_DROPS: assert property (@(posedge clk) disable iff (rst)
        (go && ctrl.enable != KEY_ON) |=> !go);  // R11

    AST_IRQ_ERR_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq_err |-> st_err);  // R10

    AST_IRQ_DONE_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq_done |-> st_done);  // R10

endmodule

bind fcmp_top fcmp_chk #(.SW(SW), .DW(DW)) i_chk (
    .clk(bus_clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ctrl(ctrl), .st_err(st_err), .st_done(st_done), .res_evt(res_evt), .go(go),
    .src(src), .irq_err(irq_err), .irq_done(irq_done)
);

// File: tb/test_fcmp_top.sv
module test_fcmp_top;

    localparam logic [2:0] AD_CTRL = 3'd0, AD_STAT = 3'd1, AD_SEED0 = 3'd2, AD_WIN0 = 3'd3,
                           AD_SEED1 = 3'd4, AD_SRC = 3'd5, AD_CNT0 = 3'd6, AD_CNT1 = 3'd7;

    localparam int NV = 7;
    localparam int V_SRC  [NV] = '{0, 0, 0, 1, 1, 2, 2};
    localparam int V_SEED [NV] = '{108, 60, 150, 43, 20, 136, 250};
    localparam int V_EXP  [NV] = '{2, 1, 1, 2, 1, 2, 1};
    localparam int V_KIND [NV] = '{5, 6, 7, 5, 6, 5, 7};

    logic        bus_clk = 1'b0, ref_clk = 1'b0;
    logic        tc0 = 1'b0, tc1 = 1'b0, tc2 = 1'b0, tc3 = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_err, irq_done;
    logic [3:0]  tst_clks;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  ended  = 1'b0;

    assign tst_clks = {tc3, tc2, tc1, tc0};

    always #5  bus_clk = ~bus_clk;
    always #10 ref_clk = ~ref_clk;
    initial begin #2; forever #5 tc0 = ~tc0; end
    always #12 tc1 = ~tc1;
    always #4  tc2 = ~tc2;
    always #20 tc3 = ~tc3;

    fcmp_top i_fcmp_top (
        .bus_clk(bus_clk), .rst(rst), .ref_clk(ref_clk), .tst_clks(tst_clks),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_err(irq_err), .irq_done(irq_done)
    );

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge bus_clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge bus_clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge bus_clk);
    endtask

    task automatic poll(input logic [31:0] mask, input int maxc, output logic [31:0] v);
        v = '0;
        for (int k = 0; k < maxc; k++) begin
            rd(AD_STAT, v);
            if ((v & mask) != 0) break;
        end
    endtask

    function automatic string kind_tag(input int k);
        case (k)
            5: return "R5";
            6: return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        repeat (190000) @(posedge bus_clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2, c0a, c1a, c0b, c1b;
        idle(20);
        @(negedge bus_clk); rst = 1'b0;
        idle(10);

        // R1: reset state
        rd(AD_STAT, v);  check(v == 0, "R1 status", v, 0);
        rd(AD_CTRL, v);  check(v == 32'h5555, "R1 control", v, 32'h5555);
        check(!irq_err && !irq_done, "R1 irqs", {irq_done, irq_err}, 0);

        // R4: keyed source select
        wr(AD_SRC, 32'hA001); rd(AD_SRC, v); check(v == 1, "R4 keyed write", v, 1);
        wr(AD_SRC, 32'h0003); rd(AD_SRC, v); check(v == 1, "R4 bad key ignored", v, 1);
        wr(AD_SRC, 32'h7002); rd(AD_SRC, v); check(v == 1, "R4 bad key ignored", v, 1);

        wr(AD_SEED0, 50);
        wr(AD_WIN0, 10);

        // Vector table: one-shot measurements with several sources and seeds
        for (int i = 0; i < NV; i++) begin
            wr(AD_SEED1, V_SEED[i]);
            wr(AD_SRC, 32'hA000 | V_SRC[i]);
            wr(AD_STAT, 3);
            wr(AD_CTRL, 32'h5A5A);
            poll(32'h3, 3000, v);
            check(v == V_EXP[i], kind_tag(V_KIND[i]), v, V_EXP[i]);
            if (i == 0) check(!irq_done, "R10 done irq masked", irq_done, 0);
            idle(60);
            rd(AD_CNT0, c0a); rd(AD_CNT1, c1a);
            if (V_KIND[i] == 7) check(c0a == 0, "R7 window readback", c0a, 0);
            if (V_KIND[i] == 5) check(c1a == 0, "R8 test readback", c1a, 0);
        end

        // R8: one-shot holds after a pass
        wr(AD_SEED1, 108); wr(AD_SRC, 32'hA000);
        wr(AD_STAT, 3); wr(AD_CTRL, 32'h5A5A);
        poll(32'h3, 3000, v);
        check(v == 2, "R8 pass", v, 2);
        idle(60);
        rd(AD_CNT0, c0a); rd(AD_CNT1, c1a);
        idle(300);
        rd(AD_CNT0, c0b); rd(AD_CNT1, c1b); rd(AD_STAT, v);
        check(v == 2, "R8 status held", v, 2);
        check(c0a == c0b, "R8 ref counter frozen", c0b, c0a);
        check(c1b == 0 && c1a == c1b, "R8 test counter frozen", c1b, 0);

        // R2, R3, R10: keyed fields, W1C and error interrupt
        wr(AD_STAT, 3);
        wr(AD_CTRL, 32'h5A53);
        rd(AD_STAT, v); check(v == 1, "R2 bad key sets error", v, 1);
        rd(AD_CTRL, v); check(v == 32'h5A55, "R2 bad field stored off", v, 32'h5A55);
        check(!irq_err, "R10 err irq masked", irq_err, 0);
        wr(AD_CTRL, 32'h55A5);
        check(irq_err, "R10 err irq raised", irq_err, 1);
        check(!irq_done, "R10 done irq low", irq_done, 0);
        wr(AD_STAT, 2);
        rd(AD_STAT, v); check(v == 1, "R3 other bit kept", v, 1);
        wr(AD_STAT, 1);
        rd(AD_STAT, v); check(v == 0, "R3 clear", v, 0);
        check(!irq_err, "R10 err irq drops", irq_err, 0);

        // R11: abort and start gating
        wr(AD_CTRL, 32'h5A5A);
        idle(20);
        wr(AD_CTRL, 32'h5A55);
        idle(400);
        rd(AD_STAT, v); check(v == 0, "R11 abort no flag", v, 0);
        wr(AD_CTRL, 32'h5AF5);
        rd(AD_STAT, v); check(v == 1, "R2 error via err field", v, 1);
        wr(AD_CTRL, 32'h5A5A);
        idle(400);
        rd(AD_STAT, v); check(v == 1, "R11 start blocked by flag", v, 1);
        wr(AD_STAT, 1);
        poll(32'h3, 3000, v);
        check(v == 2, "R11 start after clear", v, 2);
        idle(60);

        // R9: repeating mode
        wr(AD_STAT, 3);
        wr(AD_CTRL, 32'hA55A);
        poll(32'h2, 3000, v);
        check(v == 2, "R9 first pass", v, 2);
        check(irq_done, "R10 done irq raised", irq_done, 1);
        wr(AD_STAT, 2);
        rd(AD_STAT, v2); check(v2 == 0, "R3 done cleared", v2, 0);
        poll(32'h2, 3000, v);
        check(v == 2, "R9 restarted pass", v, 2);
        wr(AD_SEED1, 150);
        poll(32'h1, 5000, v);
        check(v[0] == 1'b1, "R9 failure flagged", v[0], 1);
        idle(60);
        wr(AD_STAT, 3);
        idle(400);
        rd(AD_STAT, v); check(v == 0, "R9 halted after failure", v, 0);

        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule